// File: doc/BRIEF.md
# I2C Master Interrupt Mask and Condition Unit

This unit turns the sixteen status flags of an I2C master engine into one level-sensitive interrupt line. It holds a 64-bit mask register. Software reaches the unit through a 64-bit register port that accepts only aligned 8-byte accesses. The mask can be replaced outright, or changed through a set-bits alias (OR) and a clear-bits alias (AND). The two alias offsets have a different meaning on read: one returns the raw condition word and the other returns the condition word gated by the mask.

The status flags come from the rest of the engine and are an input here. This unit places them into a fixed field of the condition word. It drives the interrupt whenever any masked condition bit is set. It also decodes the whole register window so that it can report accesses that no part of the engine claims. The status keeper uses that one-cycle report to set its invalid-command flag. A read of such an offset returns all ones. Neighbouring blocks claim their own offsets through two parameter maps, one for reads and one for writes.

Top module: `i2c_irq_cond`

## Requirements
- R1: The register offset is the byte address shifted right by 3. An access that is not 8 bytes long (req_size other than 8), or whose address has any of its low three bits set, changes no state and raises no unknown-offset pulse. If it is a read, it returns all ones.
- R2: A write to offset 0x8 replaces the mask with the write data. A read of offset 0x8 returns the mask.
- R3: A write to offset 0x9 ORs the write data into the mask.
- R4: A write to offset 0xA ANDs the write data into the mask.
- R5: A read of offset 0x9 returns the raw condition word. stat_flags[k] appears at data bit 32+k (LSB-numbered) and every other bit is zero. From stat_flags[15] down to stat_flags[0], the flags are: invalid command, parity error, overrun, access error, arbitration lost, NACK, data request, command complete, stop error, busy, not busy, reserved, SCL high, SCL low, SDA high, SDA low.
- R6: A read of offset 0xA returns the raw condition word ANDed bit by bit with the mask.
- R7: irq is a register. It equals the OR of (raw condition AND mask). After a mask write it shows the new mask at the same clock edge that stores the mask. After a change on stat_flags it follows one clock edge later. Mask bits outside bits 47..32 never raise irq.
- R8: A read or a write at an offset that neither this unit nor a neighbour claims pulses unk_access for exactly one cycle, in the cycle after the access. Such an access leaves the mask unchanged, and a read of it returns all ones.
- R9: Offsets claimed by a neighbour produce no unk_access pulse and leave the mask unchanged, and a read of them returns zero. By default, reads are claimed at offsets 0x4-0x7 and 0xB-0xE, and writes at offsets 0x4-0x7 and 0xB-0x11.
- R10: After reset the mask is zero, and irq, rsp_valid and unk_access are low.
- R11: Every read is answered with rsp_valid high for exactly one cycle, the cycle after the request. rsp_rdata carries the value as it stood in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Access strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write data |
| stat_flags | input | 16 | Status flags from the engine, invalid command at bit 15 |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data |
| unk_access | output | 1 | One-cycle pulse after an access to an unclaimed offset |
| irq | output | 1 | Level interrupt request |

## Verification
The embedded assertions check the following on every cycle:
- each of the three mask-update rules;
- that the mask holds when no mask write is taken;
- that irq tracks the masked condition with exactly one register stage;
- that an unclaimed access produces a single pulse and all-ones read data;
- that a wrong-sized access leaves no trace.

Some behaviour is only visible in the bench scenarios. These cover the placement of each of the sixteen flags in the condition word, the full classification of every offset in the window for both reads and writes, and the read-back of gated conditions. They also cover mask bits outside the flag field and the exact cycle in which irq falls after a flag clears.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int DATA_W       = 64;
  localparam int FLAG_W       = 16;
  localparam int FLAG_LSB     = 32;
  localparam int ACCESS_BYTES = 8;
  localparam int OFF_MASK     = 8;
  localparam int OFF_RAW      = 9;
  localparam int OFF_COND     = 10;

  typedef logic [DATA_W-1:0] word_t;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_MASK,
    ACC_RAW_OR,
    ACC_COND_AND,
    ACC_PEER,
    ACC_UNKNOWN,
    ACC_BADSIZE
  } acc_kind_e;

  // place the status flags into their field of the condition word
  function automatic word_t raw_from_flags(input logic [FLAG_W-1:0] f);
    word_t w;
    w = '0;
    w[FLAG_LSB +: FLAG_W] = f;
    return w;
  endfunction

  function automatic logic cond_active(input word_t raw, input word_t mask);
    return |(raw & mask);
  endfunction

  function automatic logic map_bit(input logic [63:0] map, input int idx);
    logic r;
    r = 1'b0;
    for (int i = 0; i < 64; i++)
      if (idx == i) r = map[i];
    return r;
  endfunction
endpackage

// File: rtl/i2c_irq_decode.sv
module i2c_irq_decode
  import i2c_irq_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter logic [63:0] RD_PEER_MAP = 64'h78F0,
  parameter logic [63:0] WR_PEER_MAP = 64'h3F8F0
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_size,
  output acc_kind_e         kind
);
  localparam int OFF_W = ADDR_W - 3;

  logic [OFF_W-1:0] off;
  logic             well_formed;
  logic             peer_hit;

  assign off         = req_addr[ADDR_W-1:3];
  assign well_formed = (req_addr[2:0] == 3'd0) && (req_size == 4'(ACCESS_BYTES));
  assign peer_hit    = req_write ? map_bit(WR_PEER_MAP, int'(off))
                                 : map_bit(RD_PEER_MAP, int'(off));

  always_comb begin
    kind = ACC_NONE;
    if (req_valid) begin
      if (!well_formed)                kind = ACC_BADSIZE;
      else if (int'(off) == OFF_MASK)  kind = ACC_MASK;
      else if (int'(off) == OFF_RAW)   kind = ACC_RAW_OR;
      else if (int'(off) == OFF_COND)  kind = ACC_COND_AND;
      else if (peer_hit)               kind = ACC_PEER;
      else                             kind = ACC_UNKNOWN;
    end
  end
endmodule

// File: rtl/i2c_irq_mask.sv
module i2c_irq_mask
  import i2c_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  acc_kind_e kind,
  input  logic      req_write,
  input  word_t     wdata,
  output word_t     mask_q,
  output word_t     mask_d
);
  logic mask_write;
  assign mask_write = req_write &&
                      (kind == ACC_MASK || kind == ACC_RAW_OR || kind == ACC_COND_AND);

  always_comb begin
    mask_d = mask_q;
    if (req_write) begin
      unique case (kind)
        ACC_MASK:     mask_d = wdata;
        ACC_RAW_OR:   mask_d = mask_q | wdata;
        ACC_COND_AND: mask_d = mask_q & wdata;
        default:      mask_d = mask_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  // R2
  direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ACC_MASK && req_write) |=> mask_q == $past(wdata));
  // R3
  or_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ACC_RAW_OR && req_write) |=>
      ((mask_q & $past(wdata)) == $past(wdata)) &&
      ((mask_q & ~$past(wdata)) == ($past(mask_q) & ~$past(wdata))));
  // R4
  and_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ACC_COND_AND && req_write) |=>
      ((mask_q & ~$past(wdata)) == '0) &&
      ((mask_q & $past(wdata)) == ($past(mask_q) & $past(wdata))));
  // R1
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_write |=> $stable(mask_q));
endmodule

// File: rtl/i2c_irq_line.sv
module i2c_irq_line
  import i2c_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  word_t raw,
  input  word_t mask_d,
  input  word_t mask_q,
  output logic  irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= cond_active(raw, mask_d);
  end

  // R7
  irq_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (($past(raw) & mask_q) != '0));
  // R7
  irq_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(raw) != '0);
endmodule

// File: rtl/i2c_irq_cond.sv
module i2c_irq_cond
  import i2c_irq_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter logic [63:0] RD_PEER_MAP = 64'h78F0,
  parameter logic [63:0] WR_PEER_MAP = 64'h3F8F0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_size,
  input  logic [63:0]       req_wdata,
  input  logic [15:0]       stat_flags,
  output logic              rsp_valid,
  output logic [63:0]       rsp_rdata,
  output logic              unk_access,
  output logic              irq
);
  acc_kind_e kind;
  word_t     raw_word;
  word_t     mask_q;
  word_t     mask_d;
  word_t     rd_mux;
  logic      rd_take;
  logic      unk_now;

  assign raw_word = raw_from_flags(stat_flags);
  assign rd_take  = req_valid && !req_write;
  assign unk_now  = (kind == ACC_UNKNOWN);

  i2c_irq_decode #(
    .ADDR_W(ADDR_W), .RD_PEER_MAP(RD_PEER_MAP), .WR_PEER_MAP(WR_PEER_MAP)
  ) u_decode (
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_size(req_size), .kind(kind)
  );

  i2c_irq_mask u_mask (
    .clk(clk), .rst_n(rst_n), .kind(kind), .req_write(req_write),
    .wdata(req_wdata), .mask_q(mask_q), .mask_d(mask_d)
  );

  i2c_irq_line u_line (
    .clk(clk), .rst_n(rst_n), .raw(raw_word), .mask_d(mask_d),
    .mask_q(mask_q), .irq(irq)
  );

  always_comb begin
    unique case (kind)
      ACC_MASK:     rd_mux = mask_q;
      ACC_RAW_OR:   rd_mux = raw_word;
      ACC_COND_AND: rd_mux = raw_word & mask_q;
      ACC_PEER:     rd_mux = '0;
      default:      rd_mux = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      unk_access <= 1'b0;
    end else begin
      rsp_valid  <= rd_take;
      unk_access <= unk_now;
      if (rd_take) rsp_rdata <= rd_mux;
    end
  end

  // R8
  unk_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unk_now |=> unk_access);
  // R8
  unk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !unk_now |=> !unk_access);
  // R8
  unk_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unk_now && !req_write) |=> rsp_rdata == '1);
  // R1
  badsize_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ACC_BADSIZE) |=> !unk_access && $stable(mask_q));
  // R11
  rsp_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_take |=> rsp_valid);
endmodule

// File: tb/i2c_irq_cond_bench.sv
module i2c_irq_cond_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [3:0]  req_size = 4'd8;
  logic [63:0] req_wdata = '0;
  logic [15:0] stat_flags = '0;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;
  logic        unk_access;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [63:0] mask_m = '0;

  always #5 clk = ~clk;

  i2c_irq_cond u_i2c_irq_cond (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .stat_flags(stat_flags), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .unk_access(unk_access), .irq(irq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit peer(input bit wr, input int off);
    if (off >= 4 && off <= 7) return 1'b1;
    if (off >= 11 && off <= 14) return 1'b1;
    if (wr && off >= 15 && off <= 17) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [63:0] raw_of(input logic [15:0] f);
    return {16'h0, f, 32'h0};
  endfunction

  function automatic logic [63:0] exp_read(input int off);
    if (off == 8)  return mask_m;
    if (off == 9)  return raw_of(stat_flags);
    if (off == 10) return raw_of(stat_flags) & mask_m;
    if (peer(1'b0, off)) return 64'h0;
    return '1;
  endfunction

  task automatic acc(input bit wr, input logic [7:0] addr, input logic [3:0] sz,
                     input logic [63:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 irq", irq, 0);
    check("R10 rsp_valid", rsp_valid, 0);
    check("R10 unk", unk_access, 0);
    acc(0, 8'h40, 8, 0);
    check("R10 mask", rsp_rdata, 0);
    check("R11 rsp_valid", rsp_valid, 1);
    @(negedge clk);
    check("R11 rsp_valid drop", rsp_valid, 0);

    // load a mask and flags, then sweep every offset for reads (R5 R6 R8 R9)
    acc(1, 8'h40, 8, 64'h0000_A5C3_FFFF_0000);
    mask_m = 64'h0000_A5C3_FFFF_0000;
    stat_flags = 16'hF00F;
    for (int off = 0; off < 32; off++) begin
      acc(0, 8'(off * 8), 8, 0);
      check($sformatf("R8 R9 read off %0d", off), rsp_rdata, exp_read(off));
      check($sformatf("R8 unk read off %0d", off), unk_access,
            (off < 8 || off > 10) && !peer(1'b0, off));
    end

    // write sweep over offsets not owned by this unit (R8 R9)
    for (int off = 0; off < 32; off++) begin
      if (off >= 8 && off <= 10) continue;
      acc(1, 8'(off * 8), 8, 64'h1234_5678_9ABC_DEF0);
      check($sformatf("R8 unk write off %0d", off), unk_access, !peer(1'b1, off));
      acc(0, 8'h40, 8, 0);
      check($sformatf("R9 mask kept off %0d", off), rsp_rdata, mask_m);
    end

    // per-flag sweep (R2 R3 R4 R5 R6 R7)
    for (int k = 0; k < 16; k++) begin
      logic [63:0] bitv;
      bitv = 64'h1 << (32 + k);
      @(negedge clk);
      stat_flags = 16'h1 << k;
      acc(1, 8'h40, 8, bitv);
      mask_m = bitv;
      check($sformatf("R7 irq set k=%0d", k), irq, 1);
      acc(0, 8'h48, 8, 0);
      check($sformatf("R5 raw k=%0d", k), rsp_rdata, bitv);
      acc(0, 8'h50, 8, 0);
      check($sformatf("R6 cond k=%0d", k), rsp_rdata, bitv);
      acc(1, 8'h50, 8, ~bitv);
      mask_m = mask_m & ~bitv;
      check($sformatf("R4 irq clr k=%0d", k), irq, 0);
      acc(0, 8'h40, 8, 0);
      check($sformatf("R4 mask k=%0d", k), rsp_rdata, mask_m);
      acc(1, 8'h48, 8, bitv | 64'h1);
      mask_m = mask_m | bitv | 64'h1;
      check($sformatf("R3 irq k=%0d", k), irq, 1);
      acc(0, 8'h40, 8, 0);
      check($sformatf("R3 mask k=%0d", k), rsp_rdata, mask_m);
      stat_flags = 16'h0;
      #1 check($sformatf("R7 irq held k=%0d", k), irq, 1);
      @(negedge clk);
      check($sformatf("R7 irq fall k=%0d", k), irq, 0);
    end

    // mask bits outside the flag field never raise irq (R7)
    stat_flags = 16'hFFFF;
    acc(1, 8'h40, 8, 64'hFFFF_0000_FFFF_FFFF);
    mask_m = 64'hFFFF_0000_FFFF_FFFF;
    check("R7 outside field", irq, 0);
    acc(0, 8'h50, 8, 0);
    check("R6 cond outside", rsp_rdata, 0);

    // bad sizes and misalignment (R1)
    for (int s = 1; s <= 4; s = s * 2) begin
      acc(1, 8'h40, 4'(s), 64'h0);
      check($sformatf("R1 unk size %0d", s), unk_access, 0);
      acc(0, 8'h40, 4'(s), 0);
      check($sformatf("R1 read size %0d", s), rsp_rdata, '1);
      acc(0, 8'h40, 8, 0);
      check($sformatf("R1 mask size %0d", s), rsp_rdata, mask_m);
    end
    acc(1, 8'h44, 8, 64'h0);
    check("R1 misaligned unk", unk_access, 0);
    acc(0, 8'h40, 8, 0);
    check("R1 misaligned mask", rsp_rdata, mask_m);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule